// File: doc/BRIEF.md
# Per-Register Clock-Crossing Write Bridge

This block carries register writes from a bus clock domain into a timer clock domain that runs with no fixed phase or frequency relation to it. There are five target registers: a main control word, an auxiliary control word, a command control word, a counter preload and a compare value. Each one has a private transfer channel. A channel latches the written word in a bus-side capture register and flips a request toggle. The timer side synchronizes that toggle, loads the captured word and returns an acknowledge toggle. The bus side synchronizes the acknowledge, and the channel's busy flag drops when it arrives.

Software reads one status word that holds a busy bit and a sticky error bit for each register. A write that reaches a channel while that channel is still busy is discarded, and the channel's error bit is set. The value already in flight is not affected. A compare write fills a holding buffer. The active compare value copies that buffer when the counter overflows, or when a command word that requests an update is delivered. The block also drives a timer-clock request output. This output stays high while any transfer is outstanding, even after a sleep request.

Top module: `xdom_wr_bridge`

## Requirements
- R1: Each accepted write appears exactly once at its register's timer-side output with the written value, and writes to the same register arrive in the order they were accepted.
- R2: A write to a register whose busy bit is set is discarded, and that register's error bit is set. The value in flight for that register is the one that lands.
- R3: A register's busy bit reads 1 from the first bus cycle after its write is accepted until the acknowledge returns. `b_status[4:0]` holds the busy bits and `b_status[9:5]` holds the error bits, with bit k in each field belonging to register index k.
- R4: `b_clk_req` is high whenever `b_sleep_req` is low, whenever any busy bit is set, and in any cycle in which a write is accepted. It is low only when sleep is requested and the block is idle.
- R5: The channels are independent. Writes to all five registers in consecutive bus cycles are all accepted, are all in flight together, and all land with their own values.
- R6: Register indices are 0 for main control, 1 for auxiliary control, 2 for command control, 3 for the counter preload and 4 for compare. A write with index 5, 6 or 7 changes no status bit and produces no timer-side load.
- R7: A compare write updates `t_cmp_buf` only. `t_cmp_act` keeps its value.
- R8: A one-cycle `t_ovf` pulse copies `t_cmp_buf` into `t_cmp_act` on that timer edge.
- R9: When a command-control word with bit 0 set is loaded, `t_cmp_act` takes the holding buffer on the same timer edge. With bit 0 clear, `t_cmp_act` is left unchanged.
- R10: `b_err_clr` clears all error bits. When a rejected write arrives in the same cycle as the clear, that register's error bit stays set.
- R11: After reset the status word is all zero, every timer-side register output is zero and no load strobe is active.
- R12: `t_load[k]` is high for exactly one timer cycle per transfer, and it is high in the cycle in which the new value is first visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| b_clk | input | 1 | Bus-domain clock |
| b_rst_n | input | 1 | Bus-domain asynchronous reset, active low |
| b_wr_en | input | 1 | Write strobe, one bus cycle per write |
| b_wr_sel | input | 3 | Target register index |
| b_wr_data | input | DW | Write data |
| b_err_clr | input | 1 | Clears all sticky error bits |
| b_sleep_req | input | 1 | Request to stop the timer clock |
| b_status | output | 2*5 | Error bits (upper five) and busy bits (lower five) |
| b_clk_req | output | 1 | Timer-clock request |
| t_clk | input | 1 | Timer-domain clock |
| t_rst_n | input | 1 | Timer-domain asynchronous reset, active low |
| t_ovf | input | 1 | Counter overflow pulse from the timer |
| t_load | output | 5 | Per-register load strobes |
| t_ctl_main | output | DW | Main control register |
| t_ctl_aux | output | DW | Auxiliary control register |
| t_ctl_cmd | output | DW | Command control register |
| t_cnt_val | output | DW | Counter preload value, qualified by t_load[3] |
| t_cmp_buf | output | DW | Compare holding buffer |
| t_cmp_act | output | DW | Active compare value |

## Verification
The bench drives the main transfer path with one write at a time that waits for busy to clear. These writes use all-ones, all-zero, alternating and single-bit words and cover every register index. The timer clock is faster than the bus clock in some phases and slower in others, which separates correct handshaking from accidental dependence on a clock ratio. A burst that writes all five registers back to back, under a slow timer clock, shows that the channels are independent rather than sharing one handshake. A second write to a busy channel shows that in-flight data is protected. The compare path is tried with an overflow pulse and with command words that have the update bit set and clear.

// File: rtl/xwb_pkg.sv
package xwb_pkg;

  localparam int NREG = 5;
  localparam int SELW = 3;

  localparam int CH_MAIN = 0;
  localparam int CH_AUX  = 1;
  localparam int CH_CMD  = 2;
  localparam int CH_CNT  = 3;
  localparam int CH_CMP  = 4;

  // bit of the command control word that requests a compare update
  localparam int UPD_BIT = 0;

  // one-hot write hit per channel; indices at or above NREG hit nothing
  function automatic logic [NREG-1:0] sel_decode(input logic en,
                                                 input logic [SELW-1:0] sel);
    logic [NREG-1:0] hit;
    for (int i = 0; i < NREG; i++) begin
      hit[i] = en && (sel == SELW'(i));
    end
    return hit;
  endfunction

  // a toggle pair is pending while request and returned acknowledge differ
  function automatic logic toggle_pending(input logic req, input logic ack);
    return req ^ ack;
  endfunction

  // next sticky error word: clear first, then new rejects are ORed in
  function automatic logic [NREG-1:0] err_next(input logic [NREG-1:0] cur,
                                               input logic clr,
                                               input logic [NREG-1:0] rej);
    return (clr ? '0 : cur) | rej;
  endfunction

endpackage

// File: rtl/xwb_sync.sv
module xwb_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) begin
        stg[k] <= stg[k-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/xwb_bus_chan.sv
module xwb_bus_chan #(
  parameter int DW     = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [DW-1:0] data,
  input  logic          ack_async,
  output logic [DW-1:0] cap,
  output logic          req_tgl,
  output logic          busy,
  output logic          accept,
  output logic          reject
);

  logic ack_s;

  xwb_sync #(.STAGES(STAGES), .W(1)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ack_async),
    .q     (ack_s)
  );

  assign busy   = xwb_pkg::toggle_pending(req_tgl, ack_s);
  assign accept = hit && !busy;
  assign reject = hit && busy;

  // capture register only moves on an accepted write, so it is
  // stable for the whole request/acknowledge round trip
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl <= 1'b0;
      cap     <= '0;
    end else if (accept) begin
      req_tgl <= !req_tgl;
      cap     <= data;
    end
  end

endmodule

// File: rtl/xwb_tmr_chan.sv
module xwb_tmr_chan #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic ack_tgl,
  output logic take
);

  logic req_s;

  xwb_sync #(.STAGES(STAGES), .W(1)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_async),
    .q     (req_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_tgl <= 1'b0;
    end else begin
      ack_tgl <= req_s;
    end
  end

  // one-cycle pulse per toggle edge; the acknowledge flips on the same edge
  assign take = xwb_pkg::toggle_pending(req_s, ack_tgl);

endmodule

// File: rtl/xwb_dest.sv
module xwb_dest
  import xwb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREG-1:0]          take,
  input  logic [NREG-1:0][DW-1:0]  cap,
  input  logic                     ovf,
  output logic [NREG-1:0]          load,
  output logic [NREG-1:0][DW-1:0]  dst,
  output logic [DW-1:0]            cmp_act,
  output logic                     cmp_update
);

  // command-control delivery with the update bit, or a counter overflow
  assign cmp_update = (take[CH_CMD] && cap[CH_CMD][UPD_BIT]) || ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dst  <= '0;
      load <= '0;
    end else begin
      load <= take;
      for (int i = 0; i < NREG; i++) begin
        if (take[i]) begin
          dst[i] <= cap[i];
        end
      end
    end
  end

  // active compare copies the holding buffer as it stood before this edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_act <= '0;
    end else if (cmp_update) begin
      cmp_act <= dst[CH_CMP];
    end
  end

endmodule

// File: rtl/xdom_wr_bridge.sv
module xdom_wr_bridge
  import xwb_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              b_clk,
  input  logic              b_rst_n,
  input  logic              b_wr_en,
  input  logic [SELW-1:0]   b_wr_sel,
  input  logic [DW-1:0]     b_wr_data,
  input  logic              b_err_clr,
  input  logic              b_sleep_req,
  output logic [2*NREG-1:0] b_status,
  output logic              b_clk_req,
  input  logic              t_clk,
  input  logic              t_rst_n,
  input  logic              t_ovf,
  output logic [NREG-1:0]   t_load,
  output logic [DW-1:0]     t_ctl_main,
  output logic [DW-1:0]     t_ctl_aux,
  output logic [DW-1:0]     t_ctl_cmd,
  output logic [DW-1:0]     t_cnt_val,
  output logic [DW-1:0]     t_cmp_buf,
  output logic [DW-1:0]     t_cmp_act
);

  logic [NREG-1:0]         hit_w;
  logic [NREG-1:0]         busy_w;
  logic [NREG-1:0]         accept_w;
  logic [NREG-1:0]         reject_w;
  logic [NREG-1:0]         req_tgl_w;
  logic [NREG-1:0]         ack_tgl_w;
  logic [NREG-1:0]         take_w;
  logic [NREG-1:0][DW-1:0] cap_w;
  logic [NREG-1:0][DW-1:0] dst_w;
  logic [NREG-1:0]         err_q;
  logic                    cmp_update_w;

  assign hit_w = sel_decode(b_wr_en, b_wr_sel);

  for (genvar ch = 0; ch < NREG; ch++) begin : g_chan
    xwb_bus_chan #(.DW(DW), .STAGES(SYNC_STAGES)) u_bus (
      .clk       (b_clk),
      .rst_n     (b_rst_n),
      .hit       (hit_w[ch]),
      .data      (b_wr_data),
      .ack_async (ack_tgl_w[ch]),
      .cap       (cap_w[ch]),
      .req_tgl   (req_tgl_w[ch]),
      .busy      (busy_w[ch]),
      .accept    (accept_w[ch]),
      .reject    (reject_w[ch])
    );

    xwb_tmr_chan #(.STAGES(SYNC_STAGES)) u_tmr (
      .clk       (t_clk),
      .rst_n     (t_rst_n),
      .req_async (req_tgl_w[ch]),
      .ack_tgl   (ack_tgl_w[ch]),
      .take      (take_w[ch])
    );
  end

  always_ff @(posedge b_clk or negedge b_rst_n) begin
    if (!b_rst_n) begin
      err_q <= '0;
    end else begin
      err_q <= err_next(err_q, b_err_clr, reject_w);
    end
  end

  assign b_status  = {err_q, busy_w};
  assign b_clk_req = !b_sleep_req || (|busy_w) || (|accept_w);

  xwb_dest #(.DW(DW)) u_dest (
    .clk        (t_clk),
    .rst_n      (t_rst_n),
    .take       (take_w),
    .cap        (cap_w),
    .ovf        (t_ovf),
    .load       (t_load),
    .dst        (dst_w),
    .cmp_act    (t_cmp_act),
    .cmp_update (cmp_update_w)
  );

  assign t_ctl_main = dst_w[CH_MAIN];
  assign t_ctl_aux  = dst_w[CH_AUX];
  assign t_ctl_cmd  = dst_w[CH_CMD];
  assign t_cnt_val  = dst_w[CH_CNT];
  assign t_cmp_buf  = dst_w[CH_CMP];

endmodule

// File: rtl/xwb_checker.sv
module xwb_checker
  import xwb_pkg::*;
#(
  parameter int DW = 16
) (
  input logic                    b_clk,
  input logic                    b_rst_n,
  input logic                    t_clk,
  input logic                    t_rst_n,
  input logic                    b_err_clr,
  input logic                    b_clk_req,
  input logic [NREG-1:0]         hit_w,
  input logic [NREG-1:0]         busy_w,
  input logic [NREG-1:0]         err_q,
  input logic [NREG-1:0][DW-1:0] cap_w,
  input logic                    t_ovf,
  input logic [NREG-1:0]         t_load,
  input logic [DW-1:0]           t_cmp_act
);

  for (genvar i = 0; i < NREG; i++) begin : g_ch
    assert_accept_sets_busy_R3: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (hit_w[i] && !busy_w[i]) |=> busy_w[i]);

    assert_reject_flags_R2: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (hit_w[i] && busy_w[i]) |=> (err_q[i] && $stable(cap_w[i])));

    assert_capture_held_R5: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (busy_w[i] && $past(busy_w[i])) |-> $stable(cap_w[i]));

    assert_err_sticky_R10: assert property (@(posedge b_clk) disable iff (!b_rst_n)
      (err_q[i] && !b_err_clr) |=> err_q[i]);

    assert_load_single_R12: assert property (@(posedge t_clk) disable iff (!t_rst_n)
      t_load[i] |=> !t_load[i]);
  end

  assert_clk_held_R4: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    (|busy_w) |-> b_clk_req);

  assert_cmp_act_cause_R8: assert property (@(posedge t_clk) disable iff (!t_rst_n)
    !$stable(t_cmp_act) |-> ($past(t_ovf) || t_load[CH_CMD]));

endmodule

bind xdom_wr_bridge xwb_checker #(.DW(DW)) u_chk (
  .b_clk     (b_clk),
  .b_rst_n   (b_rst_n),
  .t_clk     (t_clk),
  .t_rst_n   (t_rst_n),
  .b_err_clr (b_err_clr),
  .b_clk_req (b_clk_req),
  .hit_w     (hit_w),
  .busy_w    (busy_w),
  .err_q     (err_q),
  .cap_w     (cap_w),
  .t_ovf     (t_ovf),
  .t_load    (t_load),
  .t_cmp_act (t_cmp_act)
);

// File: tb/xdom_wr_bridge_tb_top.sv
module xdom_wr_bridge_tb_top;
  import xwb_pkg::*;

  localparam int DW   = 16;
  localparam int NVEC = 12;
  localparam int LOGN = 64;

  logic b_clk = 1'b0, t_clk = 1'b0;
  logic b_rst_n = 1'b0, t_rst_n = 1'b0;
  logic b_wr_en = 1'b0, b_err_clr = 1'b0, b_sleep_req = 1'b0, t_ovf = 1'b0;
  logic [SELW-1:0] b_wr_sel = '0;
  logic [DW-1:0]   b_wr_data = '0;
  logic [2*NREG-1:0] b_status;
  logic b_clk_req;
  logic [NREG-1:0] t_load;
  logic [DW-1:0] t_ctl_main, t_ctl_aux, t_ctl_cmd, t_cnt_val, t_cmp_buf, t_cmp_act;

  int t_half = 7;
  always #10 b_clk = ~b_clk;
  always #(t_half) t_clk = ~t_clk;

  xdom_wr_bridge #(.DW(DW)) dut_i (
    .b_clk(b_clk), .b_rst_n(b_rst_n), .b_wr_en(b_wr_en), .b_wr_sel(b_wr_sel),
    .b_wr_data(b_wr_data), .b_err_clr(b_err_clr), .b_sleep_req(b_sleep_req),
    .b_status(b_status), .b_clk_req(b_clk_req), .t_clk(t_clk), .t_rst_n(t_rst_n),
    .t_ovf(t_ovf), .t_load(t_load), .t_ctl_main(t_ctl_main), .t_ctl_aux(t_ctl_aux),
    .t_ctl_cmd(t_ctl_cmd), .t_cnt_val(t_cnt_val), .t_cmp_buf(t_cmp_buf),
    .t_cmp_act(t_cmp_act)
  );

  // {register index, data}
  localparam logic [SELW+DW-1:0] VEC [NVEC] = '{
    {3'd0, 16'hA5A5}, {3'd1, 16'h5A5A}, {3'd3, 16'hFFFF}, {3'd4, 16'h1234},
    {3'd2, 16'h0000}, {3'd0, 16'h0001}, {3'd3, 16'h0000}, {3'd1, 16'hFFFE},
    {3'd4, 16'h8000}, {3'd0, 16'h7FFF}, {3'd3, 16'hC3C3}, {3'd2, 16'h00F0}
  };

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_log [NREG][LOGN];
  logic [DW-1:0] got_log [NREG][LOGN];
  int exp_n [NREG] = '{default: 0};
  int got_n [NREG] = '{default: 0};
  logic [NREG-1:0] prev_load = '0;
  int wide_pulse = 0;

  function automatic logic [DW-1:0] dest_val(input int ch);
    case (ch)
      0:       return t_ctl_main;
      1:       return t_ctl_aux;
      2:       return t_ctl_cmd;
      3:       return t_cnt_val;
      default: return t_cmp_buf;
    endcase
  endfunction

  // timer-side monitor: record every delivered value per register
  always @(negedge t_clk) begin
    if (t_rst_n) begin
      for (int ch = 0; ch < NREG; ch++) begin
        if (t_load[ch]) begin
          if (prev_load[ch]) wide_pulse++;
          if (got_n[ch] < LOGN) got_log[ch][got_n[ch]] = dest_val(ch);
          got_n[ch]++;
        end
      end
      prev_load = t_load;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic note(input int ch, input logic [DW-1:0] d);
    if (exp_n[ch] < LOGN) exp_log[ch][exp_n[ch]] = d;
    exp_n[ch]++;
  endtask

  task automatic wr(input logic [SELW-1:0] sel, input logic [DW-1:0] d);
    @(negedge b_clk);
    b_wr_en = 1'b1; b_wr_sel = sel; b_wr_data = d;
    @(negedge b_clk);
    b_wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400; k++) begin
      if (b_status[NREG-1:0] == '0) break;
      @(negedge b_clk);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #3000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] exp_buf;
    int tot;
    exp_buf = '0;
    #55;
    b_rst_n = 1'b1; t_rst_n = 1'b1;
    @(negedge b_clk);

    // R11: reset state
    chk(b_status == '0, "R11 status", 32'(b_status), 0);
    chk({t_ctl_main, t_ctl_aux, t_ctl_cmd, t_cnt_val, t_cmp_buf, t_cmp_act} == '0 && t_load == '0,
        "R11 outputs", 32'(t_ctl_main | t_cnt_val | t_cmp_act), 0);
    chk(b_clk_req == 1'b1, "R4 awake request", 32'(b_clk_req), 1);

    // table walk: one write at a time, varying clock ratio
    for (int v = 0; v < NVEC; v++) begin
      logic [SELW-1:0] s;
      logic [DW-1:0] d;
      if (v == 6) t_half = 23;
      s = VEC[v][SELW+DW-1:DW];
      d = VEC[v][DW-1:0];
      wr(s, d);
      note(int'(s), d);
      if (s == 3'd4) exp_buf = d;
      chk(b_status[s] == 1'b1, "R3 busy after accept", 32'(b_status), 32'(1 << s));
      wait_idle();
      chk(dest_val(int'(s)) == d, "R1 R6 delivered value", 32'(dest_val(int'(s))), 32'(d));
    end
    chk(t_cmp_act == '0, "R7 active compare untouched", 32'(t_cmp_act), 0);

    // R6: out-of-range indices are ignored
    tot = got_n[0] + got_n[1] + got_n[2] + got_n[3] + got_n[4];
    wr(3'd5, 16'hDEAD);
    chk(b_status == '0, "R6 index 5 status", 32'(b_status), 0);
    wr(3'd7, 16'hBEEF);
    chk(b_status == '0, "R6 index 7 status", 32'(b_status), 0);
    repeat (30) @(negedge b_clk);
    chk(got_n[0] + got_n[1] + got_n[2] + got_n[3] + got_n[4] == tot, "R6 no load",
        32'(got_n[0] + got_n[1] + got_n[2] + got_n[3] + got_n[4]), 32'(tot));

    // R5: back-to-back writes to every register under a slow timer clock
    t_half = 37;
    repeat (4) @(negedge b_clk);
    for (int ch = 0; ch < NREG; ch++) begin
      b_wr_en = 1'b1; b_wr_sel = SELW'(ch); b_wr_data = DW'(16'h1100 * (ch + 1) + ch);
      note(ch, DW'(16'h1100 * (ch + 1) + ch));
      @(negedge b_clk);
    end
    b_wr_en = 1'b0;
    exp_buf = 16'h5504;
    chk(b_status[NREG-1:0] == 5'h1f, "R5 all in flight", 32'(b_status), 32'h1f);
    wait_idle();
    for (int ch = 0; ch < NREG; ch++) begin
      chk(dest_val(ch) == DW'(16'h1100 * (ch + 1) + ch), "R5 independent delivery",
          32'(dest_val(ch)), 32'(16'h1100 * (ch + 1) + ch));
    end

    // R2 / R10: rejected writes and error clear
    wr(3'd3, 16'h1111);
    note(3, 16'h1111);
    wr(3'd3, 16'h2222);
    chk(b_status[NREG+3] == 1'b1, "R2 error on busy write", 32'(b_status), 32'(1 << (NREG + 3)));
    @(negedge b_clk);
    b_wr_en = 1'b1; b_wr_sel = 3'd3; b_wr_data = 16'h3333; b_err_clr = 1'b1;
    @(negedge b_clk);
    b_wr_en = 1'b0; b_err_clr = 1'b0;
    chk(b_status[NREG+3] == 1'b1, "R10 reject beats clear", 32'(b_status), 32'(1 << (NREG + 3)));
    wait_idle();
    chk(t_cnt_val == 16'h1111, "R2 in-flight value kept", 32'(t_cnt_val), 32'h1111);
    @(negedge b_clk);
    b_err_clr = 1'b1;
    @(negedge b_clk);
    b_err_clr = 1'b0;
    chk(b_status == '0, "R10 errors cleared", 32'(b_status), 0);

    // R4: clock request held through a pending transfer
    t_half = 7;
    b_sleep_req = 1'b1;
    @(negedge b_clk);
    chk(b_clk_req == 1'b0, "R4 idle sleep", 32'(b_clk_req), 0);
    wr(3'd0, 16'hBEEF);
    note(0, 16'hBEEF);
    chk(b_clk_req == 1'b1, "R4 held while busy", 32'(b_clk_req), 1);
    wait_idle();
    @(negedge b_clk);
    chk(b_clk_req == 1'b0, "R4 released when idle", 32'(b_clk_req), 0);
    b_sleep_req = 1'b0;

    // R7 / R8 / R9: compare holding buffer and its copy paths
    wr(3'd4, 16'h4444);
    note(4, 16'h4444);
    wait_idle();
    chk(t_cmp_buf == 16'h4444 && t_cmp_act == '0, "R7 buffer only",
        32'(t_cmp_act), 0);
    @(negedge t_clk);
    t_ovf = 1'b1;
    @(negedge t_clk);
    t_ovf = 1'b0;
    chk(t_cmp_act == 16'h4444, "R8 overflow copy", 32'(t_cmp_act), 32'h4444);
    wr(3'd4, 16'h5555);
    note(4, 16'h5555);
    wait_idle();
    wr(3'd2, 16'h0002);
    note(2, 16'h0002);
    wait_idle();
    chk(t_cmp_act == 16'h4444, "R9 no update without bit 0", 32'(t_cmp_act), 32'h4444);
    wr(3'd2, 16'h0001);
    note(2, 16'h0001);
    wait_idle();
    chk(t_cmp_act == 16'h5555, "R9 update command", 32'(t_cmp_act), 32'h5555);

    // R1 / R12: per-register delivery log, order and pulse width
    repeat (10) @(negedge b_clk);
    for (int ch = 0; ch < NREG; ch++) begin
      bit ok;
      ok = (got_n[ch] == exp_n[ch]);
      for (int k = 0; k < LOGN; k++) begin
        if (ok && k < exp_n[ch] && got_log[ch][k] != exp_log[ch][k]) ok = 1'b0;
      end
      chk(ok, "R1 ordered log", 32'(got_n[ch]), 32'(exp_n[ch]));
    end
    chk(wide_pulse == 0, "R12 single-cycle load", 32'(wide_pulse), 0);

    summary();
    $finish;
  end

endmodule